// File: doc/BRIEF.md
# Filter Control Port with Serial Configuration and Pin Fallback

This block produces the control settings of a two-channel programmable lowpass filter: a 2-bit gain code (with its passband gain in dB), a 2-bit bandwidth code (with its master-clock divide ratio as a power of two), a shutdown flag and a general-purpose output bit. A mode input chooses where the settings come from. In pin mode, four parallel inputs drive the gain and bandwidth codes directly. In serial mode, an SPI-style stream fills an 8-bit shift register. The byte moves into a control register when chip select is released.

All external inputs pass through a synchronizer and are sampled by the block clock, so SCLK edges are found by edge detection. A three-state machine handles the serial link. DESELECTED waits. SELECTED shifts data. LATCH is a one-cycle state that loads the control register. The transitions are:
- DESELECTED to SELECTED when serial mode is active and chip select is low.
- SELECTED to LATCH when chip select rises.
- SELECTED to DESELECTED when pin mode is entered during a transfer. This is an abort, and nothing is latched.
- LATCH to DESELECTED always.

The serial data output updates on falling SCLK edges, so several of these blocks can be chained on one SDI/SDO path with a shared clock and chip select. Chip select and LPF1 share one input pin, and SCLK and LPF0 share another. The pin that carries GAIN0 in pin mode is presented in serial mode as the general-purpose output, with its own output-enable.

Top module: `filtctl_top`

## Requirements
- R1: With `pin_mode_i` high, `gain_code_o` = {`gain1_i`,`gain0_i`} and `bw_code_o` = {`cs_n_lpf1_i`,`sclk_lpf0_i`}. In this mode `shdn_o`, `gpo_o` and `gpo_oe_o` are 0.
- R2: In serial mode, while chip select is low, each rising SCLK edge shifts SDI into bit 0 of the 8-bit shift register. The first bit sent ends up in bit 7.
- R3: A rising chip select copies the shift register into the control register. Bit 7 is the gain LSB, bit 6 the gain MSB, bit 5 the bandwidth LSB, bit 4 the bandwidth MSB, bit 1 shutdown and bit 0 the general-purpose output. Bits 3 and 2 have no effect on any output.
- R4: SCLK edges while chip select is high leave both the shift register and `sdo_o` unchanged.
- R5: On each falling SCLK edge during a transfer, `sdo_o` takes bit 7 of the shift register. As a result, the byte held before a transfer comes out MSB first during that transfer.
- R6: `sdo_o` keeps its last value after chip select rises and is never cleared on deselect.
- R7: `gain_db_o` is 0, 6, 12 or 24 for gain codes 00, 01, 10 and 11.
- R8: `clk_div_log2_o` is 5 when bandwidth code bit 1 is 1. It is 7 for code 01 and 9 for code 00.
- R9: After reset the control register and shift register are zero: gain 00, bandwidth 00, no shutdown, general-purpose output low, `sdo_o` low.
- R10: With two blocks chained (first SDO into second SDI), a 16-bit transfer leaves the first 8 bits sent in the far block and the last 8 in the near block. Both blocks update on the same chip-select rise.
- R11: Entering pin mode during a transfer aborts it without changing the control register. The old serial settings return when serial mode is re-entered.
- R12: In serial mode `gpo_oe_o` is 1 and `gpo_o` equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode_i | input | 1 | 1 = parallel pin control, 0 = serial control |
| cs_n_lpf1_i | input | 1 | Chip select (active low) in serial mode; bandwidth MSB in pin mode |
| sclk_lpf0_i | input | 1 | Serial clock in serial mode; bandwidth LSB in pin mode |
| sdi_i | input | 1 | Serial data in |
| gain1_i | input | 1 | Gain MSB in pin mode |
| gain0_i | input | 1 | Gain LSB in pin mode |
| sdo_o | output | 1 | Serial data out, for chaining |
| gain_code_o | output | 2 | Active gain code |
| bw_code_o | output | 2 | Active bandwidth code |
| gain_db_o | output | 5 | Passband gain in dB |
| clk_div_log2_o | output | 4 | log2 of master-clock divide ratio |
| shdn_o | output | 1 | Low-power shutdown request |
| gpo_o | output | 1 | General-purpose output value |
| gpo_oe_o | output | 1 | Output enable for the shared GAIN0 pin |

## Verification
The hardest case to reach is an abort. Pin mode must rise while chip select is still low and a byte is only partly shifted. In that state the shared pins already carry bandwidth values, and the control register must stay untouched. The bench gets there by leaving chip select low after four SCLK pulses, raising the mode input, and checking the pin-driven outputs. It then restores chip select high, returns to serial mode and checks that the earlier serial settings come back. A second hard-to-see case is the shift register's content, which is visible only through SDO. The bench reads it back during the following transfer, including after SCLK toggles with chip select high and in the 16-bit chained transfer.

// File: rtl/filtctl_pkg.sv
package filtctl_pkg;

    localparam int CTRL_W = 8;

    // Control register field positions
    localparam int BIT_GAIN_LSB = 7;
    localparam int BIT_GAIN_MSB = 6;
    localparam int BIT_BW_LSB   = 5;
    localparam int BIT_BW_MSB   = 4;
    localparam int BIT_SHDN     = 1;
    localparam int BIT_GPO      = 0;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_SEL   = 2'd1,
        ST_LATCH = 2'd2
    } link_state_e;

    function automatic logic [4:0] gain_to_db(input logic [1:0] code);
        logic [4:0] db;
        unique case (code)
            2'b00:   db = 5'd0;
            2'b01:   db = 5'd6;
            2'b10:   db = 5'd12;
            default: db = 5'd24;
        endcase
        return db;
    endfunction

    function automatic logic [3:0] bw_to_div_log2(input logic [1:0] code);
        logic [3:0] d;
        if (code[1])      d = 4'd5;
        else if (code[0]) d = 4'd7;
        else              d = 4'd9;
        return d;
    endfunction

endpackage

// File: rtl/filtctl_sync.sv
module filtctl_sync #(
    parameter int                 WIDTH   = 6,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/filtctl_serial.sv
module filtctl_serial
    import filtctl_pkg::*;
#(
    parameter int REG_W = CTRL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_en_i,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             sdi_i,
    output logic [REG_W-1:0] shreg_o,
    output logic             sdo_o,
    output logic             load_o
);

    link_state_e state_q, state_d;
    logic [REG_W-1:0] shreg_q;
    logic sclk_q;
    logic sclk_rise, sclk_fall;

    assign sclk_rise = sclk_i & ~sclk_q;
    assign sclk_fall = ~sclk_i & sclk_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL: if (serial_en_i && !cs_n_i) state_d = ST_SEL;
            ST_SEL: begin
                if (!serial_en_i) state_d = ST_DESEL;   // abort
                else if (cs_n_i)  state_d = ST_LATCH;
            end
            ST_LATCH: state_d = ST_DESEL;
            default:  state_d = ST_DESEL;
        endcase
    end

    // Datapath driven by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shreg_q <= '0;
            sdo_o   <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (state_q == ST_SEL) begin
                if (sclk_rise) shreg_q <= {shreg_q[REG_W-2:0], sdi_i};
                if (sclk_fall) sdo_o   <= shreg_q[REG_W-1];
            end
        end
    end

    assign shreg_o = shreg_q;
    assign load_o  = (state_q == ST_LATCH);

endmodule

// File: rtl/filtctl_decode.sv
module filtctl_decode
    import filtctl_pkg::*;
(
    input  logic              pin_mode_i,
    input  logic [1:0]        pin_gain_i,
    input  logic [1:0]        pin_bw_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [1:0]        gain_code_o,
    output logic [1:0]        bw_code_o,
    output logic [4:0]        gain_db_o,
    output logic [3:0]        clk_div_log2_o,
    output logic              shdn_o,
    output logic              gpo_o,
    output logic              gpo_oe_o
);

    logic [1:0] reg_gain, reg_bw;
    logic unused_bits;

    assign reg_gain    = {ctrl_i[BIT_GAIN_MSB], ctrl_i[BIT_GAIN_LSB]};
    assign reg_bw      = {ctrl_i[BIT_BW_MSB],   ctrl_i[BIT_BW_LSB]};
    assign unused_bits = ^ctrl_i[3:2];

    always_comb begin
        gain_code_o    = pin_mode_i ? pin_gain_i : reg_gain;
        bw_code_o      = pin_mode_i ? pin_bw_i   : reg_bw;
        gain_db_o      = gain_to_db(gain_code_o);
        clk_div_log2_o = bw_to_div_log2(bw_code_o);
        shdn_o         = ~pin_mode_i & ctrl_i[BIT_SHDN];
        gpo_o          = ~pin_mode_i & ctrl_i[BIT_GPO];
        gpo_oe_o       = ~pin_mode_i;
    end

endmodule

// File: rtl/filtctl_top.sv
module filtctl_top
    import filtctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_mode_i,
    input  logic       cs_n_lpf1_i,
    input  logic       sclk_lpf0_i,
    input  logic       sdi_i,
    input  logic       gain1_i,
    input  logic       gain0_i,
    output logic       sdo_o,
    output logic [1:0] gain_code_o,
    output logic [1:0] bw_code_o,
    output logic [4:0] gain_db_o,
    output logic [3:0] clk_div_log2_o,
    output logic       shdn_o,
    output logic       gpo_o,
    output logic       gpo_oe_o
);

    localparam int NUM_IN = 6;
    // bit order: 0 mode, 1 cs/lpf1, 2 sclk/lpf0, 3 sdi, 4 gain1, 5 gain0
    localparam logic [NUM_IN-1:0] IN_RST = 6'b000011;

    logic [NUM_IN-1:0] in_s;
    logic s_pin_mode, s_cs_n, s_sclk, s_sdi, s_gain1, s_gain0;
    logic [CTRL_W-1:0] shreg, ctrl_q;
    logic load;

    filtctl_sync #(
        .WIDTH   (NUM_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({gain0_i, gain1_i, sdi_i, sclk_lpf0_i, cs_n_lpf1_i, pin_mode_i}),
        .q_o   (in_s)
    );

    assign {s_gain0, s_gain1, s_sdi, s_sclk, s_cs_n, s_pin_mode} = in_s;

    filtctl_serial #(.REG_W(CTRL_W)) u_serial (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_en_i (~s_pin_mode),
        .cs_n_i      (s_cs_n),
        .sclk_i      (s_sclk),
        .sdi_i       (s_sdi),
        .shreg_o     (shreg),
        .sdo_o       (sdo_o),
        .load_o      (load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (load) ctrl_q <= shreg;
    end

    filtctl_decode u_decode (
        .pin_mode_i     (s_pin_mode),
        .pin_gain_i     ({s_gain1, s_gain0}),
        .pin_bw_i       ({s_cs_n, s_sclk}),
        .ctrl_i         (ctrl_q),
        .gain_code_o    (gain_code_o),
        .bw_code_o      (bw_code_o),
        .gain_db_o      (gain_db_o),
        .clk_div_log2_o (clk_div_log2_o),
        .shdn_o         (shdn_o),
        .gpo_o          (gpo_o),
        .gpo_oe_o       (gpo_oe_o)
    );

endmodule

// File: rtl/filtctl_checks.sv
module filtctl_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       s_pin_mode,
    input logic       s_cs_n,
    input logic       s_gain1,
    input logic       s_gain0,
    input logic       load,
    input logic [7:0] ctrl_q,
    input logic       sdo_o,
    input logic [1:0] gain_code_o,
    input logic [1:0] bw_code_o,
    input logic [4:0] gain_db_o,
    input logic [3:0] clk_div_log2_o,
    input logic       shdn_o,
    input logic       gpo_o,
    input logic       gpo_oe_o
);

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ctrl_q));

    assert_latch_on_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(s_cs_n));

    assert_pin_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_pin_mode |-> (!shdn_o && !gpo_oe_o && gain_code_o == {s_gain1, s_gain0}));

    assert_sdo_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_cs_n) && s_cs_n) |=> $stable(sdo_o));

    assert_gain_db_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code_o == 2'b11) |-> (gain_db_o == 5'd24));

    assert_div_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_code_o == 2'b00) |-> (clk_div_log2_o == 4'd9));

    assert_gpo_R12: assert property (@(posedge clk) disable iff (!rst_n)
        gpo_oe_o |-> (gpo_o == ctrl_q[0]));

endmodule

bind filtctl_top filtctl_checks u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .s_pin_mode     (s_pin_mode),
    .s_cs_n         (s_cs_n),
    .s_gain1        (s_gain1),
    .s_gain0        (s_gain0),
    .load           (load),
    .ctrl_q         (ctrl_q),
    .sdo_o          (sdo_o),
    .gain_code_o    (gain_code_o),
    .bw_code_o      (bw_code_o),
    .gain_db_o      (gain_db_o),
    .clk_div_log2_o (clk_div_log2_o),
    .shdn_o         (shdn_o),
    .gpo_o          (gpo_o),
    .gpo_oe_o       (gpo_oe_o)
);

// File: tb/filtctl_top_bench.sv
`timescale 1ns/1ps
module filtctl_top_bench;

    localparam int HALF = 8;   // clk cycles per SCLK half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_mode = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic g1 = 1'b0, g0 = 1'b0;

    logic       sdo, sdo_far;
    logic [1:0] gain_code, bw_code, gain_code_far, bw_code_far;
    logic [4:0] gain_db, gain_db_far;
    logic [3:0] divl, divl_far;
    logic       shdn, gpo, gpo_oe, shdn_far, gpo_far, gpo_oe_far;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    filtctl_top u_filtctl_top (
        .clk(clk), .rst_n(rst_n), .pin_mode_i(pin_mode),
        .cs_n_lpf1_i(cs_n), .sclk_lpf0_i(sclk), .sdi_i(sdi),
        .gain1_i(g1), .gain0_i(g0), .sdo_o(sdo),
        .gain_code_o(gain_code), .bw_code_o(bw_code), .gain_db_o(gain_db),
        .clk_div_log2_o(divl), .shdn_o(shdn), .gpo_o(gpo), .gpo_oe_o(gpo_oe)
    );

    // Far device of the chain: its SDI is the near device's SDO
    filtctl_top u_filtctl_top_far (
        .clk(clk), .rst_n(rst_n), .pin_mode_i(pin_mode),
        .cs_n_lpf1_i(cs_n), .sclk_lpf0_i(sclk), .sdi_i(sdo),
        .gain1_i(1'b0), .gain0_i(1'b0), .sdo_o(sdo_far),
        .gain_code_o(gain_code_far), .bw_code_o(bw_code_far), .gain_db_o(gain_db_far),
        .clk_div_log2_o(divl_far), .shdn_o(shdn_far), .gpo_o(gpo_far), .gpo_oe_o(gpo_oe_far)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_db(input logic [1:0] c);
        return (c == 2'd0) ? 5'd0 : (c == 2'd1) ? 5'd6 : (c == 2'd2) ? 5'd12 : 5'd24;
    endfunction

    function automatic logic [3:0] exp_div(input logic [1:0] c);
        return c[1] ? 4'd5 : (c[0] ? 4'd7 : 4'd9);
    endfunction

    // Transfer nbits MSB first; rb collects SDO seen before each rising edge
    task automatic spi_xfer(input logic [15:0] data, input int nbits,
                            output logic [15:0] rb);
        rb = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = data[i];
            wait_clk(HALF);
            rb = {rb[14:0], sdo};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic test_reset;
        chk("R9", "gain code", {14'd0, gain_code}, 16'd0);
        chk("R9", "bw code",   {14'd0, bw_code},   16'd0);
        chk("R9", "shdn",      {15'd0, shdn},      16'd0);
        chk("R9", "gpo",       {15'd0, gpo},       16'd0);
        chk("R9", "sdo",       {15'd0, sdo},       16'd0);
        chk("R8", "div at reset", {12'd0, divl},   16'd9);
    endtask

    task automatic test_pin_mode;
        pin_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] g, b;
            g = i[1:0];
            b = 2'd3 - i[1:0];
            {g1, g0} = g;
            {cs_n, sclk} = b;
            wait_clk(6);
            chk("R1", "pin gain", {14'd0, gain_code}, {14'd0, g});
            chk("R1", "pin bw",   {14'd0, bw_code},   {14'd0, b});
            chk("R1", "pin shdn/oe", {14'd0, shdn, gpo_oe}, 16'd0);
            chk("R7", "gain dB",  {11'd0, gain_db},   {11'd0, exp_db(g)});
            chk("R8", "div",      {12'd0, divl},      {12'd0, exp_div(b)});
        end
        cs_n = 1'b1; sclk = 1'b0;
        wait_clk(4);
        pin_mode = 1'b0;
        wait_clk(6);
    endtask

    task automatic test_serial_write;
        logic [15:0] rb;
        // 1011_0011: gain 01, bw 11, shdn 1, gpo 1
        spi_xfer(16'h00B3, 8, rb);
        chk("R5", "readback after reset", rb, 16'h0000);
        chk("R3", "gain code", {14'd0, gain_code}, 16'd1);
        chk("R7", "gain dB",   {11'd0, gain_db},   16'd6);
        chk("R2", "bw code",   {14'd0, bw_code},   16'd3);
        chk("R8", "div",       {12'd0, divl},      16'd5);
        chk("R3", "shdn",      {15'd0, shdn},      16'd1);
        chk("R12", "gpo/oe",   {14'd0, gpo, gpo_oe}, 16'd3);
        chk("R6", "sdo held",  {15'd0, sdo},       16'd1);
        // 0100_1100: gain 10, bw 00, unused bits set, shdn 0, gpo 0
        spi_xfer(16'h004C, 8, rb);
        chk("R5", "readback prev byte", rb, 16'h00B3);
        chk("R3", "gain code 2", {14'd0, gain_code}, 16'd2);
        chk("R3", "bw code 2",   {14'd0, bw_code},   16'd0);
        chk("R3", "unused bits no effect", {14'd0, shdn, gpo}, 16'd0);
        chk("R6", "sdo held 2",  {15'd0, sdo},       16'd0);
    endtask

    task automatic test_ignore_deselected;
        logic [15:0] rb;
        sdi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        chk("R4", "sdo unchanged", {15'd0, sdo}, 16'd0);
        chk("R4", "gain unchanged", {14'd0, gain_code}, 16'd2);
        spi_xfer(16'h0000, 8, rb);
        chk("R4", "shift register intact", rb, 16'h004C);
    endtask

    task automatic test_abort;
        logic [15:0] rb;
        // 1110_0010: gain 11, bw 01, shdn 1, gpo 0
        spi_xfer(16'h00E2, 8, rb);
        chk("R7", "gain dB 24", {11'd0, gain_db}, 16'd24);
        chk("R8", "div 7",      {12'd0, divl},    16'd7);
        cs_n = 1'b0;
        wait_clk(HALF);
        sdi = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_clk(HALF); sclk = 1'b1;
            wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(HALF);
        g1 = 1'b0; g0 = 1'b0;
        pin_mode = 1'b1;
        wait_clk(8);
        chk("R11", "pin gain during abort", {14'd0, gain_code}, 16'd0);
        chk("R11", "pin bw during abort",   {14'd0, bw_code},   16'd0);
        chk("R11", "no shdn in pin mode",   {15'd0, shdn},      16'd0);
        cs_n = 1'b1;
        wait_clk(4);
        pin_mode = 1'b0;
        wait_clk(8);
        chk("R11", "gain restored", {14'd0, gain_code}, 16'd3);
        chk("R11", "bw restored",   {14'd0, bw_code},   16'd1);
        chk("R11", "shdn restored", {15'd0, shdn},      16'd1);
    endtask

    task automatic test_chain;
        logic [15:0] rb;
        // far byte 1001_0011 first, near byte 0110_0001 last
        spi_xfer(16'h9361, 16, rb);
        chk("R10", "near readback", rb, 16'h2F93);
        chk("R10", "near gain", {14'd0, gain_code},     16'd2);
        chk("R10", "near bw",   {14'd0, bw_code},       16'd1);
        chk("R10", "near shdn/gpo", {14'd0, shdn, gpo}, 16'd1);
        chk("R10", "far gain",  {14'd0, gain_code_far}, 16'd1);
        chk("R10", "far bw",    {14'd0, bw_code_far},   16'd2);
        chk("R10", "far shdn/gpo", {14'd0, shdn_far, gpo_far}, 16'd3);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(6);
        test_reset();
        test_pin_mode();
        test_serial_write();
        test_ignore_deselected();
        test_abort();
        test_chain();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                wait_clk(150000);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule